// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with Instruction Decoder

This block is the test access port of a chip: a sixteen-state controller that follows TMS on each rising edge of TCK, a four-bit instruction register, and three data registers. The data registers are a 32-bit identification register, a one-stage bypass register and a parameterised chain of boundary cells. The current instruction selects which data register sits between TDI and TDO. It also decides whether the output pins follow the core, follow the boundary latches, or are all released to high impedance.

Pin-side inputs (`func_in`) and core-side outputs (`core_out`, `core_oe`) are modelled as plain vectors. The pad drivers are left outside; the block only produces `pin_out` and `pin_oe`. TDO is delivered with its own enable, `tdo_oe`. The controller state is brought out on `tap_state` so that the board and the test logic can observe the state sequence.

Top module: `scan_port`

## Requirements
- R1: `tap_state` uses this encoding: 0 reset, 1 idle, 2 select-DR, 3 capture-DR, 4 shift-DR, 5 exit1-DR, 6 pause-DR, 7 exit2-DR, 8 update-DR, 9 select-IR, 10 capture-IR, 11 shift-IR, 12 exit1-IR, 13 pause-IR, 14 exit2-IR, 15 update-IR. It moves on each rising TCK edge following the standard TMS transition graph. Five rising edges with TMS high reach state 0 from any state, and a low `trst_n` forces state 0 asynchronously.
- R2: The instruction shift stage is 4 bits wide and loads 0001 (a 1 in bit 0) in capture-IR. In shift-IR, TDI enters at bit 3 and bit 0 leaves first on TDO.
- R3: The active instruction is 0001 (identification) after `trst_n` and whenever the controller is in state 0. A newly shifted instruction takes effect only on the falling TCK edge in update-IR.
- R4: Opcode 0001 places the 32-bit identification parameter on the scan path. It is read bit 0 first, and bit 0 of that parameter is 1.
- R5: Opcode 1111 places the one-stage bypass register on the scan path. That register captures 0, so a bit presented on TDI reaches TDO one shift cycle later.
- R6: Any opcode other than 0000, 0001, 0100, 0101 and 1111 behaves as bypass, with `pin_out = core_out` and `pin_oe = core_oe`.
- R7: Opcode 0000 puts the pins in test mode. `pin_out` is the output part of the boundary update latches, and every bit of `pin_oe` is 1. Capture-DR loads the boundary chain from the pins.
- R8: The boundary update latches change only on the falling TCK edge in update-DR, never on a rising edge.
- R9: Opcode 0101 captures `{core_out, func_in}` into the boundary chain, with `func_in` in the low bits next to TDO. The pins stay in normal mode. Update-DR preloads the shifted value into the update latches.
- R10: Opcode 0100 drives every bit of `pin_oe` to 0 and routes the scan path through the bypass register. This lasts until another instruction is made active in a later update-IR.
- R11: TDO and `tdo_oe` change only on falling TCK edges. `tdo_oe` is 1 only while the controller is in shift-IR or shift-DR.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out, changes on falling TCK |
| tdo_oe | output | 1 | Enable for the TDO pad |
| tap_state | output | 4 | Current controller state (encoding in R1) |
| func_in | input | N_IN | Values present on the input pins |
| core_out | input | N_OUT | Output data from the core |
| core_oe | input | N_OUT | Output enables from the core |
| pin_out | output | N_OUT | Data to the output pads |
| pin_oe | output | N_OUT | Enables to the output pads |

## Verification
A state change appears on `tap_state` just after the rising TCK edge that consumes the TMS bit. TDO, `tdo_oe`, the active instruction and the boundary update latches follow the falling edge half a cycle later. The bench therefore drives TMS and TDI just after a falling edge. It reads every result one nanosecond after the next falling edge, and in a scan that means the bit on TDO before each shift step. Where the edge itself matters (the instruction in update-IR, the boundary update, TDO enable), the bench also samples just after the rising edge. It expects the old value there and the new value after the falling edge.

// File: rtl/scan_pkg.sv
package scan_pkg;

  localparam int IR_W = 4;

  typedef enum logic [3:0] {
    ST_TLR    = 4'd0,  ST_RTI    = 4'd1,  ST_SEL_DR = 4'd2,  ST_CAP_DR = 4'd3,
    ST_SH_DR  = 4'd4,  ST_EX1_DR = 4'd5,  ST_PA_DR  = 4'd6,  ST_EX2_DR = 4'd7,
    ST_UP_DR  = 4'd8,  ST_SEL_IR = 4'd9,  ST_CAP_IR = 4'd10, ST_SH_IR  = 4'd11,
    ST_EX1_IR = 4'd12, ST_PA_IR  = 4'd13, ST_EX2_IR = 4'd14, ST_UP_IR  = 4'd15
  } tap_st_e;

  localparam logic [IR_W-1:0] OP_EXTEST = 4'b0000;
  localparam logic [IR_W-1:0] OP_IDCODE = 4'b0001;
  localparam logic [IR_W-1:0] OP_HIGHZ  = 4'b0100;
  localparam logic [IR_W-1:0] OP_SAMPLE = 4'b0101;
  localparam logic [IR_W-1:0] OP_BYPASS = 4'b1111;
  localparam logic [IR_W-1:0] IR_CAPT   = 4'b0001;

  typedef enum logic [1:0] { DR_BYP = 2'd0, DR_ID = 2'd1, DR_BSR = 2'd2 } dr_sel_e;

  typedef struct packed {
    dr_sel_e sel;
    logic    test_mode;
    logic    hiz;
  } op_dec_t;

  // Instruction decode: scan path, pin test mode, global output disable.
  function automatic op_dec_t decode_op(logic [IR_W-1:0] op);
    op_dec_t d;
    d = '{sel: DR_BYP, test_mode: 1'b0, hiz: 1'b0};
    case (op)
      OP_EXTEST: d = '{sel: DR_BSR, test_mode: 1'b1, hiz: 1'b0};
      OP_IDCODE: d.sel = DR_ID;
      OP_HIGHZ:  d.hiz = 1'b1;
      OP_SAMPLE: d.sel = DR_BSR;
      default:   d.sel = DR_BYP;
    endcase
    return d;
  endfunction

  // Controller transition graph.
  function automatic tap_st_e tap_next(tap_st_e s, logic tms);
    tap_st_e n;
    case (s)
      ST_TLR:    n = tms ? ST_TLR    : ST_RTI;
      ST_RTI:    n = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: n = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: n = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  n = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: n = tms ? ST_UP_DR  : ST_PA_DR;
      ST_PA_DR:  n = tms ? ST_EX2_DR : ST_PA_DR;
      ST_EX2_DR: n = tms ? ST_UP_DR  : ST_SH_DR;
      ST_UP_DR:  n = tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: n = tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: n = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  n = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: n = tms ? ST_UP_IR  : ST_PA_IR;
      ST_PA_IR:  n = tms ? ST_EX2_IR : ST_PA_IR;
      ST_EX2_IR: n = tms ? ST_UP_IR  : ST_SH_IR;
      ST_UP_IR:  n = tms ? ST_SEL_DR : ST_RTI;
      default:   n = ST_TLR;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/scan_tap_fsm.sv
module scan_tap_fsm
  import scan_pkg::*;
(
  input  logic    tck,
  input  logic    trst_n,
  input  logic    tms,
  output tap_st_e state
);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state <= ST_TLR;
    else         state <= tap_next(state, tms);
  end

endmodule

// File: rtl/scan_ir.sv
module scan_ir
  import scan_pkg::*;
(
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tdi,
  input  tap_st_e         state,
  output logic [IR_W-1:0] ir_sr_q,
  output logic [IR_W-1:0] ir_q,
  output logic            ir_so
);

  // shift stage on the rising edge
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir_sr_q <= IR_CAPT;
    end else if (state == ST_CAP_IR) begin
      ir_sr_q <= IR_CAPT;
    end else if (state == ST_SH_IR) begin
      ir_sr_q <= {tdi, ir_sr_q[IR_W-1:1]};
    end
  end

  // active instruction on the falling edge
  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir_q <= OP_IDCODE;
    end else if (state == ST_TLR) begin
      ir_q <= OP_IDCODE;
    end else if (state == ST_UP_IR) begin
      ir_q <= ir_sr_q;
    end
  end

  assign ir_so = ir_sr_q[0];

endmodule

// File: rtl/scan_bsr.sv
module scan_bsr
  import scan_pkg::*;
#(
  parameter int N_IN  = 4,
  parameter int N_OUT = 4,
  localparam int NB   = N_IN + N_OUT
) (
  input  logic             tck,
  input  logic             trst_n,
  input  logic             tdi,
  input  tap_st_e          state,
  input  logic             sel,
  input  logic [N_IN-1:0]  func_in,
  input  logic [N_OUT-1:0] core_out,
  output logic [NB-1:0]    upd_q,
  output logic             so
);

  logic [NB-1:0] sr_q;
  logic [NB-1:0] cap_vec;
  logic [NB-1:0] sh_in;

  assign cap_vec = {core_out, func_in};

  for (genvar i = 0; i < NB; i++) begin : g_cell
    if (i == NB - 1) begin : g_head
      assign sh_in[i] = tdi;
    end else begin : g_link
      assign sh_in[i] = sr_q[i+1];
    end

    always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
        sr_q[i] <= 1'b0;
      end else if (sel && state == ST_CAP_DR) begin
        sr_q[i] <= cap_vec[i];
      end else if (sel && state == ST_SH_DR) begin
        sr_q[i] <= sh_in[i];
      end
    end
  end

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n)                        upd_q <= '0;
    else if (sel && state == ST_UP_DR)  upd_q <= sr_q;
  end

  assign so = sr_q[0];

endmodule

// File: rtl/scan_port.sv
module scan_port
  import scan_pkg::*;
#(
  parameter int          N_IN   = 4,
  parameter int          N_OUT  = 4,
  parameter logic [31:0] IDCODE = 32'h2C4B_90A7
) (
  input  logic             tck,
  input  logic             trst_n,
  input  logic             tms,
  input  logic             tdi,
  output logic             tdo,
  output logic             tdo_oe,
  output logic [3:0]       tap_state,
  input  logic [N_IN-1:0]  func_in,
  input  logic [N_OUT-1:0] core_out,
  input  logic [N_OUT-1:0] core_oe,
  output logic [N_OUT-1:0] pin_out,
  output logic [N_OUT-1:0] pin_oe
);

  localparam int NB = N_IN + N_OUT;

  tap_st_e         st;
  logic [IR_W-1:0] ir_q;
  logic [IR_W-1:0] ir_sr_q;
  logic            ir_so;
  op_dec_t         dec;
  logic [NB-1:0]   bsr_upd;
  logic            bsr_so;
  logic [31:0]     id_sr;
  logic            byp_q;
  logic            dr_so;
  logic            tdo_nxt;
  logic            in_shift;

  // named events for the checker
  logic sel_bsr, sel_id, sel_byp;

  scan_tap_fsm u_fsm (
    .tck(tck), .trst_n(trst_n), .tms(tms), .state(st)
  );

  scan_ir u_ir (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .state(st),
    .ir_sr_q(ir_sr_q), .ir_q(ir_q), .ir_so(ir_so)
  );

  assign dec     = decode_op(ir_q);
  assign sel_bsr = (dec.sel == DR_BSR);
  assign sel_id  = (dec.sel == DR_ID);
  assign sel_byp = (dec.sel == DR_BYP);

  scan_bsr #(.N_IN(N_IN), .N_OUT(N_OUT)) u_bsr (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .state(st), .sel(sel_bsr),
    .func_in(func_in), .core_out(core_out), .upd_q(bsr_upd), .so(bsr_so)
  );

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      id_sr <= '0;
      byp_q <= 1'b0;
    end else begin
      if (sel_id && st == ST_CAP_DR)     id_sr <= IDCODE;
      else if (sel_id && st == ST_SH_DR) id_sr <= {tdi, id_sr[31:1]};
      if (sel_byp && st == ST_CAP_DR)     byp_q <= 1'b0;
      else if (sel_byp && st == ST_SH_DR) byp_q <= tdi;
    end
  end

  always_comb begin
    case (dec.sel)
      DR_BSR:  dr_so = bsr_so;
      DR_ID:   dr_so = id_sr[0];
      default: dr_so = byp_q;
    endcase
  end

  assign in_shift = (st == ST_SH_DR) || (st == ST_SH_IR);
  assign tdo_nxt  = (st == ST_SH_IR) ? ir_so : dr_so;

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo    <= in_shift ? tdo_nxt : 1'b0;
      tdo_oe <= in_shift;
    end
  end

  assign tap_state = st;
  assign pin_out   = dec.test_mode ? bsr_upd[NB-1:N_IN] : core_out;
  assign pin_oe    = dec.hiz ? '0 : (dec.test_mode ? '1 : core_oe);

endmodule

// File: rtl/scan_port_chk.sv
module scan_port_chk #(
  parameter int N_IN  = 4,
  parameter int N_OUT = 4
) (
  input logic                   tck,
  input logic                   trst_n,
  input logic                   tms,
  input logic [3:0]             tap_state,
  input logic                   tdo_oe,
  input logic [3:0]             ir_q,
  input logic [3:0]             ir_sr_q,
  input logic [N_IN+N_OUT-1:0]  bsr_upd,
  input logic [N_OUT-1:0]       pin_oe
);

  p_reset_hold_r1: assert property (@(posedge tck) disable iff (!trst_n)
    (tap_state == 4'd0 && tms) |=> tap_state == 4'd0);

  p_reset_leave_r1: assert property (@(posedge tck) disable iff (!trst_n)
    (tap_state == 4'd0 && !tms) |=> tap_state == 4'd1);

  p_ir_capture_r2: assert property (@(posedge tck) disable iff (!trst_n)
    (tap_state == 4'd10) |=> ir_sr_q == 4'b0001);

  p_ir_only_on_update_r3: assert property (@(posedge tck) disable iff (!trst_n)
    !(tap_state == 4'd15 || tap_state == 4'd0) |-> $stable(ir_q));

  p_bsr_only_on_update_r8: assert property (@(posedge tck) disable iff (!trst_n)
    (tap_state != 4'd8) |-> $stable(bsr_upd));

  p_highz_all_off_r10: assert property (@(posedge tck) disable iff (!trst_n)
    (ir_q == 4'b0100) |-> pin_oe == '0);

  p_tdo_oe_shift_only_r11: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_oe |-> (tap_state == 4'd4 || tap_state == 4'd11));

endmodule

bind scan_port scan_port_chk #(.N_IN(N_IN), .N_OUT(N_OUT)) chk_i (
  .tck(tck), .trst_n(trst_n), .tms(tms), .tap_state(tap_state),
  .tdo_oe(tdo_oe), .ir_q(ir_q), .ir_sr_q(ir_sr_q), .bsr_upd(bsr_upd),
  .pin_oe(pin_oe)
);

// File: tb/scan_port_tb.sv
`timescale 1ns/1ps
module scan_port_tb_top;

  localparam logic [31:0] ID = 32'h2C4B_90A7;

  logic       tck = 1'b0;
  logic       trst_n = 1'b0;
  logic       tms = 1'b1;
  logic       tdi = 1'b0;
  logic [3:0] func_in = 4'h0;
  logic [3:0] core_out = 4'h0;
  logic [3:0] core_oe = 4'h0;
  logic       tdo, tdo_oe;
  logic [3:0] tap_state, pin_out, pin_oe;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #5 tck = ~tck;

  scan_port dut_i (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
    .tap_state(tap_state), .func_in(func_in), .core_out(core_out), .core_oe(core_oe),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  // {tms, expected state}
  localparam logic [4:0] WALK [40] = '{
    {1'b0,4'd1},  {1'b0,4'd1},  {1'b1,4'd2},  {1'b0,4'd3},  {1'b0,4'd4},
    {1'b0,4'd4},  {1'b1,4'd5},  {1'b0,4'd6},  {1'b0,4'd6},  {1'b1,4'd7},
    {1'b0,4'd4},  {1'b1,4'd5},  {1'b1,4'd8},  {1'b1,4'd2},  {1'b0,4'd3},
    {1'b1,4'd5},  {1'b1,4'd8},  {1'b0,4'd1},  {1'b1,4'd2},  {1'b1,4'd9},
    {1'b0,4'd10}, {1'b1,4'd12}, {1'b0,4'd13}, {1'b1,4'd14}, {1'b0,4'd11},
    {1'b1,4'd12}, {1'b1,4'd15}, {1'b1,4'd2},  {1'b1,4'd9},  {1'b0,4'd10},
    {1'b0,4'd11}, {1'b1,4'd12}, {1'b0,4'd13}, {1'b1,4'd14}, {1'b1,4'd15},
    {1'b0,4'd1},  {1'b1,4'd2},  {1'b1,4'd9},  {1'b1,4'd0},  {1'b1,4'd0}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d);
    tms = m; tdi = d;
    @(posedge tck); @(negedge tck); #1;
  endtask

  task automatic do_reset();
    trst_n = 1'b0; tms = 1'b1;
    #12; trst_n = 1'b1;
    @(negedge tck); #1;
  endtask

  // from idle; when stop is set, ends in exit1-IR
  task automatic scan_ir(input logic [3:0] op, input bit stop, output logic [3:0] got);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 4; i++) begin
      got[i] = tdo;
      step(i == 3, op[i]);
    end
    if (!stop) begin step(1, 0); step(0, 0); end
  endtask

  // from idle; when stop is set, ends in exit1-DR
  task automatic scan_dr(input int n, input logic [63:0] din, input bit stop,
                         output logic [63:0] dout);
    dout = '0;
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < n; i++) begin
      dout[i] = tdo;
      step(i == n - 1, din[i]);
    end
    if (!stop) begin step(1, 0); step(0, 0); end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [3:0]  irg;
    logic [63:0] dq;
    do_reset();
    check("R1 reset state", tap_state, 0);
    check("R11 tdo_oe off in reset", tdo_oe, 0);
    check("R3 pins normal after reset", pin_oe, core_oe);

    // table walk over the transition graph
    for (int k = 0; k < 40; k++) begin
      step(WALK[k][4], 1'b0);
      check($sformatf("R1 walk step %0d", k), tap_state, WALK[k][3:0]);
    end

    // identification readout after reset
    do_reset(); step(0, 0);
    scan_dr(32, 0, 0, dq);
    check("R4 R3 id readout", dq[31:0], ID);
    check("R4 id bit0 is one", dq[0], 1);

    // five ones from shift-DR
    step(1, 0); step(0, 0); step(0, 0);
    check("R1 in shift-DR", tap_state, 4);
    for (int k = 0; k < 5; k++) step(1, 0);
    check("R1 five ones reach reset", tap_state, 0);
    step(0, 0);

    // IR capture value and bypass
    scan_ir(4'b1111, 0, irg);
    check("R2 ir capture 0001", irg, 4'b0001);
    scan_dr(9, 64'h16D, 0, dq);
    check("R5 bypass one-cycle delay", dq[8:0], {8'h6D, 1'b0});

    // unassigned opcode
    core_out = 4'h6; core_oe = 4'b1001;
    scan_ir(4'b0011, 0, irg);
    check("R6 unknown pin_oe normal", pin_oe, 4'b1001);
    check("R6 unknown pin_out normal", pin_out, 4'h6);
    scan_dr(6, 64'h2B, 0, dq);
    check("R6 unknown acts as bypass", dq[5:0], {5'h0B, 1'b0});

    // sample / preload
    func_in = 4'hA; core_out = 4'h3; core_oe = 4'b0110;
    scan_ir(4'b0101, 0, irg);
    scan_dr(8, 64'h96, 1, dq);
    check("R9 sample capture", dq[7:0], 8'h3A);
    step(1, 0); step(0, 0);
    check("R9 pins normal out", pin_out, 4'h3);
    check("R9 pins normal oe", pin_oe, 4'b0110);

    // extest drives from preloaded latches
    scan_ir(4'b0000, 0, irg);
    check("R7 R9 extest shows preload", pin_out, 4'h9);
    check("R7 extest oe all on", pin_oe, 4'hF);
    scan_dr(8, 64'h5C, 1, dq);
    check("R7 extest capture", dq[7:0], 8'h3A);
    check("R8 no change before update", pin_out, 4'h9);
    tms = 1'b1; @(posedge tck); #1;
    check("R8 still old after rising edge", pin_out, 4'h9);
    @(negedge tck); #1;
    check("R8 new after falling edge", pin_out, 4'h5);
    step(0, 0);

    // highz takes effect in update-IR
    core_oe = 4'b1011;
    scan_ir(4'b0100, 1, irg);
    check("R3 old instruction until update", pin_oe, 4'hF);
    tms = 1'b1; @(posedge tck); #1;
    check("R3 old instruction at rising edge", pin_oe, 4'hF);
    @(negedge tck); #1;
    check("R10 highz at update falling edge", pin_oe, 4'h0);
    step(0, 0);
    scan_dr(5, 64'h13, 0, dq);
    check("R10 highz routes bypass", dq[4:0], {4'h3, 1'b0});
    check("R10 highz persists", pin_oe, 4'h0);
    scan_ir(4'b1111, 0, irg);
    check("R10 released by new instruction", pin_oe, 4'b1011);

    // tdo enable timing
    step(1, 0); step(0, 0);
    tms = 1'b0; @(posedge tck); #1;
    check("R11 state shift-DR", tap_state, 4);
    check("R11 oe waits for falling edge", tdo_oe, 0);
    @(negedge tck); #1;
    check("R11 oe on in shift", tdo_oe, 1);
    step(1, 0);
    check("R11 oe off in exit1", tdo_oe, 0);
    step(1, 0); step(0, 0);

    // reset state restores identification
    scan_ir(4'b0100, 0, irg);
    for (int k = 0; k < 5; k++) step(1, 0);
    check("R3 reset state restores pins", pin_oe, 4'b1011);
    step(0, 0);
    scan_dr(32, 0, 0, dq);
    check("R3 identification restored", dq[31:0], ID);
    scan_ir(4'b0000, 0, irg);
    trst_n = 1'b0; #3;
    check("R1 async reset", tap_state, 0);
    check("R3 trst restores pins", pin_oe, 4'b1011);
    trst_n = 1'b1;

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule